// File: doc/BRIEF.md
# Two-Channel Byte-Packing DMA Engine

This block moves data between byte-wide peripheral ports and a 16-bit memory on behalf of two independent channels. Each channel is programmed with a memory address, a byte count, a peripheral port address and a control word, and is then started. A channel running toward memory reads one byte at a time from its peripheral and writes each pair of bytes to memory as one 16-bit word. A channel running toward the device reads one word from memory and hands its two bytes to the peripheral one after the other. When the byte count is odd, the last memory access is byte-wide.

A shared arbiter chooses which channel owns each bus cycle. A channel with its priority bit set beats one without it. Two channels at the same priority take turns, one bus cycle each. A peripheral paces its channel with a request line. It can also end the transfer early with a stop line, but only on a channel whose control word allows this. On completion a channel raises its interrupt and records whether the stop line ended it. A lock output holds the bus for other masters while any locked channel is running.

There is one bus port for memory and IO cycles. It uses a plain request/acknowledge handshake with one cycle outstanding at a time.

Top module: `dma2_engine`

## Requirements
- R1: After reset the bus request, interrupts, stop flags and lock are all low. A control write (register select 0) to an idle channel loads bit0 go, bit1 direction (1 = memory to device), bit2 stop enable, bit3 lock and bit4 priority. The same write clears that channel's interrupt and stop flag and starts the channel when go is 1. Register select 1 loads the memory address, 2 the byte count and 3 the port address.
- R2: Register writes to a channel that is running are ignored.
- R3: Device-to-memory: the first byte read from the peripheral goes into data bits [7:0] and the second into [15:8]. Each pair is written as one 16-bit memory cycle (wide = 1) at the current address, and the address then advances by 2.
- R4: Memory-to-device: each 16-bit memory read is followed by two peripheral writes, the byte from bits [7:0] first and then the byte from [15:8]. The address advances by 2.
- R5: With an odd byte count, the final memory access is byte-wide (wide = 0, data in bits [7:0]) and the address advances by 1. Memory past the last byte is not touched.
- R6: A peripheral cycle starts only while the channel's request input is high. The environment holds the request high until that cycle begins. Peripheral cycles are byte-wide, carry data in bits [7:0] and use the channel's port address.
- R7: When the byte count is used up and the last held byte has been written, the channel stops, raises its interrupt and leaves its stop flag low. A channel started with a count of 0 ends with no bus cycle.
- R8: With stop enabled, a high stop input ends the transfer after the current bus cycle. The interrupt and the stop flag are then set and no further cycles issue. With stop disabled the input has no effect.
- R9: While both channels have cycles ready at equal priority, successive bus cycles alternate between them.
- R10: While both channels have cycles ready, a channel with its priority bit set gets every cycle until it finishes.
- R11: The lock output is high while any running channel has its lock bit set, and low otherwise.
- R12: Once the bus request is raised, it and the address, write, memory-select, width and write-data outputs hold steady until the acknowledge. The request drops in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 1 | Channel selected by the write |
| cfg_reg | input | 2 | Register select: 0 control, 1 memory address, 2 byte count, 3 port |
| cfg_wdata | input | CFG_W | Register write data |
| dev_req | input | 2 | Per-channel peripheral data request |
| dev_halt | input | 2 | Per-channel peripheral stop request |
| chan_irq | output | 2 | Per-channel completion interrupt |
| halt_seen | output | 2 | Per-channel flag: transfer ended by the stop input |
| bus_lock | output | 1 | Bus lock for other masters |
| bus_req | output | 1 | Bus cycle request |
| bus_mem | output | 1 | 1 = memory cycle, 0 = peripheral cycle |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_wide | output | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr | output | ADDR_W | Cycle address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with the acknowledge |
| bus_ack | input | 1 | Cycle acknowledge |

## Verification
A wrong byte-holding count or lane choice shows up within one transfer as swapped or missing bytes in memory, or at the peripheral. A wrong address step shows up as a write landing past the end of the region on the next memory cycle. A wrong arbitration history shows up at once as two same-channel cycles in a row while both channels are ready. A wrong termination state shows up as extra bus cycles or a missing interrupt within a few cycles of the stop input or of the final byte. The bench sweeps every byte count from 0 to 6 on both channels in both directions, so every packing phase and odd-length tail is checked against arithmetic expectations.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 16;

   typedef enum logic [1:0] {
      REG_CTRL  = 2'd0,
      REG_MADDR = 2'd1,
      REG_COUNT = 2'd2,
      REG_PORT  = 2'd3
   } dma2_reg_e;

   localparam int CTL_GO     = 0;
   localparam int CTL_TO_DEV = 1;
   localparam int CTL_HALTEN = 2;
   localparam int CTL_LOCK   = 3;
   localparam int CTL_PRIO   = 4;

   typedef struct packed {
      logic to_dev;
      logic halt_en;
      logic lock;
      logic prio;
   } dma2_ctrl_t;
endpackage

// File: rtl/dma2_arb.sv
module dma2_arb #(
   parameter int N_CH = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_CH-1:0]         ready,
   input  logic [N_CH-1:0]         prio,
   input  logic                    ack,
   output logic                    req,
   output logic [$clog2(N_CH)-1:0] owner,
   output logic [N_CH-1:0]         grant
);
   localparam int IDX_W = $clog2(N_CH);

   if (N_CH < 2) begin : g_bad_nch
      $error("dma2_arb needs at least two channels");
   end

   logic [N_CH-1:0]  hi, cand;
   logic [IDX_W-1:0] last, pick;
   logic             busy;

   always_comb begin
      logic found;
      hi    = ready & prio;
      cand  = (|hi) ? hi : ready;
      pick  = last;
      found = 1'b0;
      for (int k = 1; k <= N_CH; k++) begin
         int idx;
         idx = (int'(last) + k) % N_CH;
         if (!found && cand[idx]) begin
            pick  = IDX_W'(idx);
            found = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         owner <= '0;
         last  <= IDX_W'(N_CH - 1);
      end else if (busy) begin
         if (ack) busy <= 1'b0;
      end else if (|cand) begin
         busy  <= 1'b1;
         owner <= pick;
         last  <= pick;
      end
   end

   assign req = busy;

   for (genvar i = 0; i < N_CH; i++) begin : g_grant
      assign grant[i] = busy && (owner == IDX_W'(i));
   end
endmodule

// File: rtl/dma2_chan.sv
module dma2_chan
   import dma2_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 16,
   parameter int PORT_W = 16,
   parameter int CFG_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_reg,
   input  logic [CFG_W-1:0]  wr_data,
   input  logic              drq,
   input  logic              halt,
   input  logic              grant,
   input  logic              ack,
   input  logic [WORD_W-1:0] rdata,
   output logic              ready,
   output logic              prio,
   output logic              op_mem,
   output logic              op_we,
   output logic              op_wide,
   output logic [ADDR_W-1:0] op_addr,
   output logic [WORD_W-1:0] op_wdata,
   output logic              lock_o,
   output logic              irq_o,
   output logic              halted_o
);
   dma2_ctrl_t        ctrl;
   logic              busy;
   logic [ADDR_W-1:0] maddr;
   logic [CNT_W-1:0]  count;
   logic [PORT_W-1:0] port;
   logic [WORD_W-1:0] hold;
   logic [1:0]        hcnt;

   logic all_done, halt_req, mem_step, fin_norm, fin_halt, step_ack;

   assign all_done = (count == '0) && (hcnt == 2'd0);
   assign halt_req = ctrl.halt_en && halt;

   always_comb begin
      if (ctrl.to_dev) mem_step = (hcnt == 2'd0) && (count != '0);
      else             mem_step = (hcnt == 2'd2) || ((hcnt == 2'd1) && (count == '0));
   end

   assign ready    = busy && !all_done && !halt_req && (mem_step || drq);
   assign prio     = ctrl.prio;
   assign op_mem   = mem_step;
   assign op_we    = ctrl.to_dev ? !mem_step : mem_step;
   assign op_wide  = mem_step && (ctrl.to_dev ? (count > CNT_W'(1)) : (hcnt == 2'd2));
   assign op_addr  = mem_step ? maddr : ADDR_W'(port);
   assign op_wdata = mem_step ? hold : {{(WORD_W-BYTE_W){1'b0}}, hold[BYTE_W-1:0]};
   assign lock_o   = busy && ctrl.lock;

   assign step_ack = grant && ack;
   assign fin_norm = busy && !grant && all_done;
   assign fin_halt = busy && !grant && halt_req && !all_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl     <= '0;
         busy     <= 1'b0;
         maddr    <= '0;
         count    <= '0;
         port     <= '0;
         hold     <= '0;
         hcnt     <= 2'd0;
         irq_o    <= 1'b0;
         halted_o <= 1'b0;
      end else if (wr_en && !busy) begin
         unique case (dma2_reg_e'(wr_reg))
            REG_CTRL: begin
               ctrl.to_dev  <= wr_data[CTL_TO_DEV];
               ctrl.halt_en <= wr_data[CTL_HALTEN];
               ctrl.lock    <= wr_data[CTL_LOCK];
               ctrl.prio    <= wr_data[CTL_PRIO];
               busy         <= wr_data[CTL_GO];
               irq_o        <= 1'b0;
               halted_o     <= 1'b0;
               hold         <= '0;
               hcnt         <= 2'd0;
            end
            REG_MADDR: maddr <= wr_data[ADDR_W-1:0];
            REG_COUNT: count <= wr_data[CNT_W-1:0];
            REG_PORT:  port  <= wr_data[PORT_W-1:0];
            default: ;
         endcase
      end else if (fin_norm || fin_halt) begin
         busy     <= 1'b0;
         irq_o    <= 1'b1;
         halted_o <= fin_halt;
      end else if (step_ack) begin
         if (mem_step) begin
            if (ctrl.to_dev) begin
               if (op_wide) begin
                  hold  <= rdata;
                  hcnt  <= 2'd2;
                  maddr <= maddr + ADDR_W'(2);
               end else begin
                  hold  <= {{(WORD_W-BYTE_W){1'b0}}, rdata[BYTE_W-1:0]};
                  hcnt  <= 2'd1;
                  maddr <= maddr + ADDR_W'(1);
               end
            end else begin
               maddr <= maddr + ADDR_W'(hcnt);
               hcnt  <= 2'd0;
               hold  <= '0;
            end
         end else begin
            count <= count - CNT_W'(1);
            if (ctrl.to_dev) begin
               hold <= {{BYTE_W{1'b0}}, hold[WORD_W-1:BYTE_W]};
               hcnt <= hcnt - 2'd1;
            end else begin
               if (hcnt == 2'd0) hold[BYTE_W-1:0]      <= rdata[BYTE_W-1:0];
               else              hold[WORD_W-1:BYTE_W] <= rdata[BYTE_W-1:0];
               hcnt <= hcnt + 2'd1;
            end
         end
      end
   end
endmodule

// File: rtl/dma2_engine.sv
module dma2_engine
   import dma2_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int CNT_W  = 16,
   parameter int PORT_W = 16,
   parameter int CFG_W  = (ADDR_W > CNT_W) ? ((ADDR_W > PORT_W) ? ADDR_W : PORT_W)
                                           : ((CNT_W > PORT_W) ? CNT_W : PORT_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_ch,
   input  logic [1:0]        cfg_reg,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic [1:0]        dev_req,
   input  logic [1:0]        dev_halt,
   output logic [1:0]        chan_irq,
   output logic [1:0]        halt_seen,
   output logic              bus_lock,
   output logic              bus_req,
   output logic              bus_mem,
   output logic              bus_we,
   output logic              bus_wide,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [15:0]       bus_wdata,
   input  logic [15:0]       bus_rdata,
   input  logic              bus_ack
);
   localparam int N_CH = 2;

   if (PORT_W > ADDR_W) begin : g_bad_port
      $error("port address must fit in the bus address");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("byte count needs at least two bits");
   end
   if (CFG_W < ADDR_W || CFG_W < CNT_W || CFG_W < PORT_W) begin : g_bad_cfg
      $error("register write data too narrow");
   end

   logic [N_CH-1:0]   v_ready, v_prio, v_mem, v_we, v_wide, v_lock, v_grant;
   logic [ADDR_W-1:0] v_addr  [N_CH];
   logic [15:0]       v_wdata [N_CH];
   logic [0:0]        arb_owner;

   dma2_arb #(.N_CH(N_CH)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .ready (v_ready),
      .prio  (v_prio),
      .ack   (bus_ack),
      .req   (bus_req),
      .owner (arb_owner),
      .grant (v_grant)
   );

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      dma2_chan #(
         .ADDR_W (ADDR_W),
         .CNT_W  (CNT_W),
         .PORT_W (PORT_W),
         .CFG_W  (CFG_W)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (cfg_we && (cfg_ch == 1'(i))),
         .wr_reg   (cfg_reg),
         .wr_data  (cfg_wdata),
         .drq      (dev_req[i]),
         .halt     (dev_halt[i]),
         .grant    (v_grant[i]),
         .ack      (bus_ack),
         .rdata    (bus_rdata),
         .ready    (v_ready[i]),
         .prio     (v_prio[i]),
         .op_mem   (v_mem[i]),
         .op_we    (v_we[i]),
         .op_wide  (v_wide[i]),
         .op_addr  (v_addr[i]),
         .op_wdata (v_wdata[i]),
         .lock_o   (v_lock[i]),
         .irq_o    (chan_irq[i]),
         .halted_o (halt_seen[i])
      );
   end

   assign bus_mem   = v_mem[arb_owner];
   assign bus_we    = v_we[arb_owner];
   assign bus_wide  = v_wide[arb_owner];
   assign bus_addr  = v_addr[arb_owner];
   assign bus_wdata = v_wdata[arb_owner];
   assign bus_lock  = |v_lock;
endmodule

// File: rtl/dma2_engine_chk.sv
module dma2_engine_chk #(
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_ack,
   input logic              bus_mem,
   input logic              bus_we,
   input logic              bus_wide,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [15:0]       bus_wdata,
   input logic [1:0]        dev_req,
   input logic [1:0]        dev_halt,
   input logic [1:0]        chan_irq,
   input logic [1:0]        halt_seen,
   input logic [0:0]        owner
);
   // R12: fields hold while waiting for the acknowledge
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) &&
                                 $stable(bus_mem) && $stable(bus_wide) && $stable(bus_wdata)));

   // R12: request released right after the acknowledge
   p_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack) |=> !bus_req);

   // R6: peripheral cycles only start on a live request and are byte-wide
   p_drq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_req) && !bus_mem) |-> dev_req[owner]);

   p_io_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_mem) |-> !bus_wide);

   // R7: a channel never completes while it owns a bus cycle
   p_irq_idle_r7_c0: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_irq[0]) |-> !$past(bus_req && owner == 1'b0));

   p_irq_idle_r7_c1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_irq[1]) |-> !$past(bus_req && owner == 1'b1));

   // R8: a stop flag only follows a high stop input
   p_halt_r8_c0: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_seen[0]) |-> ($past(dev_halt[0]) && chan_irq[0]));

   p_halt_r8_c1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_seen[1]) |-> ($past(dev_halt[1]) && chan_irq[1]));
endmodule

bind dma2_engine dma2_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req   (bus_req),
   .bus_ack   (bus_ack),
   .bus_mem   (bus_mem),
   .bus_we    (bus_we),
   .bus_wide  (bus_wide),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .dev_req   (dev_req),
   .dev_halt  (dev_halt),
   .chan_irq  (chan_irq),
   .halt_seen (halt_seen),
   .owner     (arb_owner)
);

// File: tb/tb_dma2_engine.sv
module tb_dma2_engine;
   localparam int ADDR_W = 20;
   localparam int CFG_W  = 20;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic              cfg_ch = 1'b0;
   logic [1:0]        cfg_reg = 2'd0;
   logic [CFG_W-1:0]  cfg_wdata = '0;
   logic [1:0]        dev_req = 2'b00;
   logic [1:0]        dev_halt = 2'b00;
   logic [1:0]        chan_irq, halt_seen;
   logic              bus_lock, bus_req, bus_mem, bus_we, bus_wide;
   logic [ADDR_W-1:0] bus_addr;
   logic [15:0]       bus_wdata;
   logic [15:0]       bus_rdata = 16'h0;
   logic              bus_ack = 1'b0;

   always #5 clk = ~clk;

   dma2_engine dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_reg(cfg_reg),
      .cfg_wdata(cfg_wdata), .dev_req(dev_req), .dev_halt(dev_halt),
      .chan_irq(chan_irq), .halt_seen(halt_seen), .bus_lock(bus_lock),
      .bus_req(bus_req), .bus_mem(bus_mem), .bus_we(bus_we), .bus_wide(bus_wide),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
   );

   int checks = 0;
   int failures = 0;
   int hs_err = 0;

   logic [7:0] memb [4096];
   logic [7:0] dev_out [2][64];
   int         dev_out_n [2];
   int         src_idx [2];
   bit         lg_ch [512];
   bit         lg_mem [512];
   bit         lg_wide [512];
   int         log_n = 0;

   function automatic logic [7:0] src_b(input int ch, input int k);
      return 8'(ch * 64 + k * 7 + 3);
   endfunction

   function automatic logic [7:0] fill_b(input int a);
      return 8'(a ^ 'h5A);
   endfunction

   function automatic int base_of(input int ch);
      return (ch == 0) ? 'h100 : 'h900;
   endfunction

   function automatic int port_of(input int ch);
      return (ch == 0) ? 'h30 : 'h50;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // bus responder with 0..2 cycles of latency
   initial begin
      bit         seen = 0;
      int         wait_left = 0;
      int         lat = 0;
      logic [ADDR_W-1:0] c_addr = '0;
      logic       c_we = 0, c_mem = 0, c_wide = 0;
      logic [15:0] c_wdata = '0;
      forever begin
         @(negedge clk);
         if (bus_ack) begin
            bus_ack = 1'b0;
            if (bus_req) hs_err++;
         end else if (bus_req && rst_n) begin
            if (!seen) begin
               seen = 1; c_addr = bus_addr; c_we = bus_we; c_mem = bus_mem;
               c_wide = bus_wide; c_wdata = bus_wdata;
               wait_left = lat; lat = (lat + 1) % 3;
            end else if (c_addr != bus_addr || c_we != bus_we || c_mem != bus_mem ||
                         c_wide != bus_wide || c_wdata != bus_wdata) begin
               hs_err++;
            end
            if (wait_left == 0) begin
               int a;
               int ch;
               a  = int'(bus_addr);
               ch = bus_mem ? int'(a >= 'h800) : int'(a == 'h50);
               if (bus_mem && bus_we) begin
                  memb[a[11:0]] = bus_wdata[7:0];
                  if (bus_wide) memb[(a + 1) % 4096] = bus_wdata[15:8];
               end else if (bus_mem) begin
                  bus_rdata = bus_wide ? {memb[(a + 1) % 4096], memb[a[11:0]]}
                                       : {8'hEE, memb[a[11:0]]};
               end else if (bus_we) begin
                  if (dev_out_n[ch] < 64) dev_out[ch][dev_out_n[ch]] = bus_wdata[7:0];
                  dev_out_n[ch]++;
               end else begin
                  bus_rdata = {8'hC3, src_b(ch, src_idx[ch])};
                  src_idx[ch]++;
               end
               if (log_n < 512) begin
                  lg_ch[log_n] = ch[0]; lg_mem[log_n] = bus_mem; lg_wide[log_n] = bus_wide;
               end
               log_n++;
               bus_ack = 1'b1;
               seen = 0;
            end else begin
               wait_left--;
            end
         end
      end
   end

   task automatic cfg_write(input int ch, input int sel, input int val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_ch = 1'(ch); cfg_reg = 2'(sel); cfg_wdata = CFG_W'(val);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic clear_models(input int ch);
      for (int k = 0; k < 32; k++) memb[(base_of(ch) + k) % 4096] = fill_b(base_of(ch) + k);
      dev_out_n[ch] = 0;
      src_idx[ch]   = 0;
   endtask

   task automatic wait_irq(input logic [1:0] mask, input string tag);
      int t = 0;
      while (((chan_irq & mask) != mask) && t < 3000) begin
         @(negedge clk);
         t++;
      end
      chk((chan_irq & mask) == mask, tag, int'(chan_irq), int'(mask));
   endtask

   task automatic tally(output int io, output int mem, output int wide);
      io = 0; mem = 0; wide = 0;
      for (int k = 0; k < log_n && k < 512; k++) begin
         if (lg_mem[k]) begin mem++; if (lg_wide[k]) wide++; end
         else io++;
      end
   endtask

   task automatic run_one(input int ch, input int to_dev, input int n, input int lk);
      int io, mem, wide;
      clear_models(ch);
      log_n = 0;
      dev_req = 2'b11;
      cfg_write(ch, 1, base_of(ch));
      cfg_write(ch, 2, n);
      cfg_write(ch, 3, port_of(ch));
      cfg_write(ch, 0, 1 | (to_dev << 1) | (lk << 3));
      if (n > 0) chk(bus_lock == 1'(lk), "R11 lock while running", int'(bus_lock), lk);
      wait_irq(2'(1 << ch), "R7 completion interrupt");
      @(negedge clk);
      chk(halt_seen[ch] == 1'b0, "R7 stop flag low on count end", int'(halt_seen[ch]), 0);
      chk(bus_lock == 1'b0, "R11 lock released", int'(bus_lock), 0);
      tally(io, mem, wide);
      chk(io == n, "R6 peripheral cycle count", io, n);
      chk(mem == (n + 1) / 2, "R3 R4 memory cycle count", mem, (n + 1) / 2);
      chk(wide == n / 2, "R5 wide memory cycle count", wide, n / 2);
      if (n == 0) chk(log_n == 0, "R7 zero count no cycles", log_n, 0);
      if (to_dev == 0) begin
         for (int k = 0; k < n; k++)
            chk(memb[base_of(ch) + k] == src_b(ch, k), (k % 2 == 0) ? "R3 low lane byte" : "R3 high lane byte",
                int'(memb[base_of(ch) + k]), int'(src_b(ch, k)));
         chk(memb[base_of(ch) + n] == fill_b(base_of(ch) + n), "R5 memory past end untouched",
             int'(memb[base_of(ch) + n]), int'(fill_b(base_of(ch) + n)));
      end else begin
         chk(dev_out_n[ch] == n, "R4 peripheral byte count", dev_out_n[ch], n);
         for (int k = 0; k < n; k++)
            chk(dev_out[ch][k] == fill_b(base_of(ch) + k), "R4 R5 byte order to device",
                int'(dev_out[ch][k]), int'(fill_b(base_of(ch) + k)));
      end
   endtask

   task automatic run_pair(input int prio1);
      clear_models(0); clear_models(1);
      log_n = 0;
      dev_req = 2'b00;
      for (int ch = 0; ch < 2; ch++) begin
         cfg_write(ch, 1, base_of(ch));
         cfg_write(ch, 2, 6);
         cfg_write(ch, 3, port_of(ch));
         cfg_write(ch, 0, 1 | ((ch == 1 && prio1 == 1) ? (1 << 4) : 0));
      end
      @(negedge clk);
      dev_req = 2'b11;
      wait_irq(2'b11, "R9 R10 both channels complete");
      chk(log_n == 18, "R9 R10 total cycles", log_n, 18);
      for (int k = 0; k < 18; k++) begin
         if (prio1 == 0) begin
            if (k > 0) chk(lg_ch[k] != lg_ch[k-1], "R9 equal priority alternation",
                           int'(lg_ch[k]), int'(!lg_ch[k-1]));
         end else begin
            chk(lg_ch[k] == (k < 9), "R10 priority channel first", int'(lg_ch[k]), int'(k < 9));
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int io, mem, wide, snap;
      dev_out_n[0] = 0; dev_out_n[1] = 0; src_idx[0] = 0; src_idx[1] = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_req == 1'b0, "R1 reset bus idle", int'(bus_req), 0);
      chk(chan_irq == 2'b00, "R1 reset interrupts", int'(chan_irq), 0);
      chk(halt_seen == 2'b00, "R1 reset stop flags", int'(halt_seen), 0);
      chk(bus_lock == 1'b0, "R1 reset lock", int'(bus_lock), 0);

      for (int ch = 0; ch < 2; ch++)
         for (int d = 0; d < 2; d++)
            for (int n = 0; n <= 6; n++)
               run_one(ch, d, n, n % 2);

      // R6 and R2: request low stalls; writes to a running channel are ignored
      clear_models(0); log_n = 0; dev_req = 2'b00;
      cfg_write(0, 1, base_of(0)); cfg_write(0, 2, 4); cfg_write(0, 3, port_of(0));
      cfg_write(0, 0, 1);
      repeat (30) @(negedge clk);
      chk(log_n == 0, "R6 no peripheral cycle without request", log_n, 0);
      chk(chan_irq[0] == 1'b0, "R6 stalled channel not done", int'(chan_irq[0]), 0);
      cfg_write(0, 2, 100);
      cfg_write(0, 1, 'h200);
      dev_req = 2'b01;
      wait_irq(2'b01, "R2 stalled transfer completes");
      tally(io, mem, wide);
      chk(io == 4, "R2 count write while running ignored", io, 4);
      for (int k = 0; k < 4; k++)
         chk(memb[base_of(0) + k] == src_b(0, k), "R2 address write while running ignored",
             int'(memb[base_of(0) + k]), int'(src_b(0, k)));

      // R8: stop enabled
      clear_models(0); log_n = 0; dev_req = 2'b11;
      cfg_write(0, 1, base_of(0)); cfg_write(0, 2, 40); cfg_write(0, 3, port_of(0));
      cfg_write(0, 0, 1 | (1 << 2));
      while (log_n < 5) @(negedge clk);
      dev_halt[0] = 1'b1;
      wait_irq(2'b01, "R8 stop ends transfer");
      dev_halt[0] = 1'b0;
      chk(halt_seen[0] == 1'b1, "R8 stop flag set", int'(halt_seen[0]), 1);
      tally(io, mem, wide);
      chk(io < 40, "R8 transfer cut short", io, 39);
      snap = log_n;
      repeat (6) @(negedge clk);
      chk(log_n == snap && bus_req == 1'b0, "R8 no cycles after stop", log_n, snap);
      cfg_write(0, 0, 0);
      chk(chan_irq[0] == 1'b0, "R1 control write clears interrupt", int'(chan_irq[0]), 0);
      chk(halt_seen[0] == 1'b0, "R1 control write clears stop flag", int'(halt_seen[0]), 0);

      // R8: stop disabled, input ignored
      clear_models(1); log_n = 0; dev_req = 2'b11; dev_halt[1] = 1'b1;
      cfg_write(1, 1, base_of(1)); cfg_write(1, 2, 6); cfg_write(1, 3, port_of(1));
      cfg_write(1, 0, 1);
      wait_irq(2'b10, "R8 disabled stop completes");
      dev_halt[1] = 1'b0;
      tally(io, mem, wide);
      chk(io == 6, "R8 disabled stop has no effect", io, 6);
      chk(halt_seen[1] == 1'b0, "R8 disabled stop flag low", int'(halt_seen[1]), 0);

      run_pair(0);
      run_pair(1);

      chk(hs_err == 0, "R12 handshake held and released", hs_err, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule